// File: doc/BRIEF.md
# UART Flag, Control and Interrupt Unit

This block holds the software-visible state of a byte UART that has a transmit holding buffer in front of a transmit shift register. A serial core, not part of this block, reports three kinds of event: a shifted byte has left the line, a received byte has arrived, and that byte has a parity or framing fault. The unit tracks the two transmit occupancy flags and the receive-full flag, and it keeps sticky error flags plus a summary error. It hands a byte to the shifter with a one-cycle load pulse when the shift register is free and transmission is enabled. One registered interrupt line is raised whenever any flag is set whose enable bit is also set.

Software reaches the unit over a simple register bus with a 3-bit address, separate read and write strobes and 16-bit data. Read data is registered and appears one cycle after the read strobe. A read of the receive data register is what consumes a byte: that read clears the receive-full flag and every receive error. A separate error view lets the error flags be cleared without taking the byte.

Top module: `uart_flag_unit`

## Requirements
- R1: After reset the status register reads 0x0003, with transmit holding empty at bit 0 and shift empty at bit 1. Control, mask and error view read 0, and the interrupt output is low.
- R2: A write to address 4 stores its low DATA_W bits and clears bit 0. With transmit enable (control bit 0) set and bit 1 set, the byte moves to the shifter. `tx_load` pulses for one cycle with the byte on `tx_byte`, bit 0 sets again and bit 1 clears.
- R3: A `tx_shift_done` pulse sets bit 1. The transfer is complete only when status bits 0 and 1 are both set.
- R4: While transmit enable is clear, a written byte stays in the holding buffer, giving status 0x0002 with no load. It is handed over once the enable is set.
- R5: Writing control with bit 2 set discards the held byte and sets bit 0 without loading it. Control bit 2 always reads back as 0.
- R6: With receive enable (control bit 1) set, a received byte sets receive-full (bit 2). Its parity fault sets bit 3 and its framing fault sets bit 4. Both error bits are sticky.
- R7: A byte that arrives while bit 2 is set is dropped and sets overrun (bit 5). The stored byte is kept.
- R8: Status bit 6 is the OR of bits 3, 4 and 5.
- R9: A read of address 5 returns the stored byte and clears bits 2 through 6.
- R10: Address 1 shows only bits 3 to 6 of the status register. A write there clears each of bits 3, 4 and 5 whose written bit is 0 and leaves the rest unchanged.
- R11: While receive enable is clear, receive events change no flag and no data.
- R12: Address 3 holds interrupt enables at bits 0, 1, 2 and 6; all other bits read 0. `irq` equals the OR of status bits ANDed with their enables, registered one cycle.
- R13: `bus_rdata` holds the addressed register one cycle after `bus_rd` and is 0 in every other cycle. Control is at address 2 and the status register at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| bus_addr | input | 3 | register select |
| bus_wr | input | 1 | write strobe |
| bus_rd | input | 1 | read strobe |
| bus_wdata | input | 16 | write data |
| bus_rdata | output | 16 | registered read data |
| tx_load | output | 1 | one-cycle hand-over pulse to the shifter |
| tx_byte | output | DATA_W | byte handed to the shifter |
| tx_shift_done | input | 1 | shifter has finished its byte |
| rx_valid | input | 1 | received byte strobe |
| rx_byte | input | DATA_W | received byte |
| rx_perr | input | 1 | parity fault of the received byte |
| rx_ferr | input | 1 | framing fault of the received byte |
| irq | output | 1 | registered interrupt request |

## Verification
The bench builds the unit with DATA_W set to 4, so every data value fits in a sixteen-step loop. Every transmit value passes through the load path, and every receive value is paired with all four parity and framing combinations, with the status word and error view predicted arithmetically each time. The four interrupt enables are swept through all sixteen settings in three distinct flag states, which covers every term of the interrupt OR.

// File: rtl/ufu_pkg.sv
package ufu_pkg;
  localparam int unsigned ST_TBE  = 0;
  localparam int unsigned ST_TSBE = 1;
  localparam int unsigned ST_RBF  = 2;
  localparam int unsigned ST_PE   = 3;
  localparam int unsigned ST_FE   = 4;
  localparam int unsigned ST_OV   = 5;
  localparam int unsigned ST_SUM  = 6;

  localparam int unsigned CT_TE  = 0;
  localparam int unsigned CT_RE  = 1;
  localparam int unsigned CT_CLR = 2;

  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_STAT = 3'd0,
    A_ERRV = 3'd1,
    A_CTRL = 3'd2,
    A_MASK = 3'd3,
    A_TXD  = 3'd4,
    A_RXD  = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/ufu_tx_track.sv
module ufu_tx_track #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              te_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              flush_i,
  input  logic              done_i,
  output logic              tbe_o,
  output logic              tsbe_o,
  output logic              load_o,
  output logic [DATA_W-1:0] byte_o
);
  logic [DATA_W-1:0] hold_q;
  logic              move;

  assign move = !tbe_o && tsbe_o && te_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      tbe_o  <= 1'b1;
      tsbe_o <= 1'b1;
      load_o <= 1'b0;
      byte_o <= '0;
      hold_q <= '0;
    end else begin
      load_o <= move;
      if (move) begin
        byte_o <= hold_q;
        tsbe_o <= 1'b0;
      end else if (done_i) begin
        tsbe_o <= 1'b1;
      end
      if (wr_i) begin
        hold_q <= wdata_i;
        tbe_o  <= 1'b0;
      end else if (flush_i || move) begin
        tbe_o <= 1'b1;
      end
    end
  end

  p_load_takes_shift_r2: assert property (@(posedge clk) disable iff (rst)
    load_o |-> !tsbe_o);
  p_done_frees_shift_r3: assert property (@(posedge clk) disable iff (rst)
    (done_i && !tsbe_o) |=> tsbe_o);
  p_hold_while_off_r4: assert property (@(posedge clk) disable iff (rst)
    !te_i |=> !load_o);
endmodule

// File: rtl/ufu_rx_track.sv
module ufu_rx_track #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              re_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              perr_i,
  input  logic              ferr_i,
  input  logic              rd_clr_i,
  input  logic              err_wr_i,
  input  logic [2:0]        keep_i,
  output logic              rbf_o,
  output logic              pe_o,
  output logic              fe_o,
  output logic              ov_o,
  output logic [DATA_W-1:0] data_o
);
  logic              evt;
  logic              rbf_n, pe_n, fe_n, ov_n;
  logic [DATA_W-1:0] data_n;

  assign evt = valid_i && re_i;

  always_comb begin
    rbf_n  = rbf_o;
    pe_n   = pe_o;
    fe_n   = fe_o;
    ov_n   = ov_o;
    data_n = data_o;
    if (rd_clr_i) begin
      rbf_n = 1'b0;
      pe_n  = 1'b0;
      fe_n  = 1'b0;
      ov_n  = 1'b0;
    end
    if (err_wr_i) begin
      pe_n = pe_n & keep_i[0];
      fe_n = fe_n & keep_i[1];
      ov_n = ov_n & keep_i[2];
    end
    if (evt) begin
      if (rbf_o && !rd_clr_i) begin
        ov_n = 1'b1;
      end else begin
        rbf_n  = 1'b1;
        data_n = byte_i;
        pe_n   = pe_n | perr_i;
        fe_n   = fe_n | ferr_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rbf_o  <= 1'b0;
      pe_o   <= 1'b0;
      fe_o   <= 1'b0;
      ov_o   <= 1'b0;
      data_o <= '0;
    end else begin
      rbf_o  <= rbf_n;
      pe_o   <= pe_n;
      fe_o   <= fe_n;
      ov_o   <= ov_n;
      data_o <= data_n;
    end
  end

  p_overrun_keeps_r7: assert property (@(posedge clk) disable iff (rst)
    (evt && rbf_o && !rd_clr_i) |=> (ov_o && data_o == $past(data_o)));
  p_read_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_clr_i && !evt) |=> (!rbf_o && !pe_o && !fe_o && !ov_o));
  p_ignored_when_off_r11: assert property (@(posedge clk) disable iff (rst)
    (!re_i && !rd_clr_i && !err_wr_i) |=> ($stable(rbf_o) && $stable(data_o) && $stable(ov_o)));
endmodule

// File: rtl/ufu_irq_merge.sv
module ufu_irq_merge #(
  parameter int unsigned REG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] status_i,
  input  logic [REG_W-1:0] mask_i,
  output logic             irq_o
);
  logic [REG_W-1:0] hit;

  for (genvar i = 0; i < REG_W; i++) begin : g_hit
    assign hit[i] = status_i[i] & mask_i[i];
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |hit;
  end

  p_irq_follows_r12: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == |($past(status_i) & $past(mask_i))));
endmodule

// File: rtl/uart_flag_unit.sv
module uart_flag_unit #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned REG_W  = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ufu_pkg::ADDR_W-1:0] bus_addr,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic [REG_W-1:0]          bus_wdata,
  output logic [REG_W-1:0]          bus_rdata,
  output logic                      tx_load,
  output logic [DATA_W-1:0]         tx_byte,
  input  logic                      tx_shift_done,
  input  logic                      rx_valid,
  input  logic [DATA_W-1:0]         rx_byte,
  input  logic                      rx_perr,
  input  logic                      rx_ferr,
  output logic                      irq
);
  import ufu_pkg::*;

  localparam logic [REG_W-1:0] CTRL_KEEP = REG_W'((1 << CT_TE) | (1 << CT_RE));
  localparam logic [REG_W-1:0] MASK_KEEP = REG_W'((1 << ST_TBE) | (1 << ST_TSBE) |
                                                  (1 << ST_RBF) | (1 << ST_SUM));
  localparam logic [REG_W-1:0] ERR_VIEW  = REG_W'((1 << ST_PE) | (1 << ST_FE) |
                                                  (1 << ST_OV) | (1 << ST_SUM));

  reg_sel_e         sel;
  logic [REG_W-1:0] ctrl_q, mask_q, stat;
  logic             wr_ctrl, wr_mask, wr_txd, wr_errv, rd_rxd, flush;
  logic             tbe, tsbe, rbf, pe, fe, ov;
  logic [DATA_W-1:0] rx_data;

  assign sel     = reg_sel_e'(bus_addr);
  assign wr_ctrl = bus_wr && (sel == A_CTRL);
  assign wr_mask = bus_wr && (sel == A_MASK);
  assign wr_txd  = bus_wr && (sel == A_TXD);
  assign wr_errv = bus_wr && (sel == A_ERRV);
  assign rd_rxd  = bus_rd && (sel == A_RXD);
  assign flush   = wr_ctrl && bus_wdata[CT_CLR];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      mask_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata & CTRL_KEEP;
      if (wr_mask) mask_q <= bus_wdata & MASK_KEEP;
    end
  end

  ufu_tx_track #(.DATA_W(DATA_W)) u_tx (
    .clk    (clk),
    .rst    (rst),
    .te_i   (ctrl_q[CT_TE]),
    .wr_i   (wr_txd),
    .wdata_i(bus_wdata[DATA_W-1:0]),
    .flush_i(flush),
    .done_i (tx_shift_done),
    .tbe_o  (tbe),
    .tsbe_o (tsbe),
    .load_o (tx_load),
    .byte_o (tx_byte)
  );

  ufu_rx_track #(.DATA_W(DATA_W)) u_rx (
    .clk     (clk),
    .rst     (rst),
    .re_i    (ctrl_q[CT_RE]),
    .valid_i (rx_valid),
    .byte_i  (rx_byte),
    .perr_i  (rx_perr),
    .ferr_i  (rx_ferr),
    .rd_clr_i(rd_rxd),
    .err_wr_i(wr_errv),
    .keep_i  ({bus_wdata[ST_OV], bus_wdata[ST_FE], bus_wdata[ST_PE]}),
    .rbf_o   (rbf),
    .pe_o    (pe),
    .fe_o    (fe),
    .ov_o    (ov),
    .data_o  (rx_data)
  );

  always_comb begin
    stat          = '0;
    stat[ST_TBE]  = tbe;
    stat[ST_TSBE] = tsbe;
    stat[ST_RBF]  = rbf;
    stat[ST_PE]   = pe;
    stat[ST_FE]   = fe;
    stat[ST_OV]   = ov;
    stat[ST_SUM]  = pe | fe | ov;
  end

  ufu_irq_merge #(.REG_W(REG_W)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .status_i(stat),
    .mask_i  (mask_q),
    .irq_o   (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (sel)
        A_STAT:  bus_rdata <= stat;
        A_ERRV:  bus_rdata <= stat & ERR_VIEW;
        A_CTRL:  bus_rdata <= ctrl_q;
        A_MASK:  bus_rdata <= mask_q;
        A_RXD:   bus_rdata <= REG_W'(rx_data);
        default: bus_rdata <= '0;
      endcase
    end else begin
      bus_rdata <= '0;
    end
  end

  p_rdata_idle_r13: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));
  p_ctrl_clr_reads_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && sel == A_CTRL) |=> !bus_rdata[CT_CLR]);
endmodule

// File: tb/uart_flag_unit_bench.sv
module uart_flag_unit_bench;
  localparam int DW = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        tx_load;
  logic [DW-1:0] tx_byte;
  logic        tx_shift_done = 1'b0;
  logic        rx_valid = 1'b0;
  logic [DW-1:0] rx_byte = '0;
  logic        rx_perr = 1'b0, rx_ferr = 1'b0;
  logic        irq;

  int total = 0;
  int bad = 0;
  int loads = 0;
  logic [DW-1:0] last_load = '0;
  logic [15:0] rv;

  always #2 clk = ~clk;

  uart_flag_unit #(.DATA_W(DW), .REG_W(16)) u_uart_flag_unit (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_load(tx_load), .tx_byte(tx_byte),
    .tx_shift_done(tx_shift_done), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .irq(irq)
  );

  always @(negedge clk) begin
    if (!rst && tx_load) begin
      loads++;
      last_load = tx_byte;
    end
  end

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    d = bus_rdata; bus_rd = 1'b0;
  endtask

  task automatic rx_evt(input logic [DW-1:0] b, input logic pe, input logic fe);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b; rx_perr = pe; rx_ferr = fe;
    @(negedge clk);
    rx_valid = 1'b0; rx_perr = 1'b0; rx_ferr = 1'b0;
  endtask

  task automatic shift_done();
    @(negedge clk);
    tx_shift_done = 1'b1;
    @(negedge clk);
    tx_shift_done = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog got=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    rd(3'd0, rv); check("R1 status", rv, 16'h0003);
    rd(3'd2, rv); check("R1 ctrl", rv, 16'h0000);
    rd(3'd3, rv); check("R1 mask", rv, 16'h0000);
    rd(3'd1, rv); check("R1 errview", rv, 16'h0000);
    check("R1 irq", {15'd0, irq}, 16'h0000);
    check("R13 rdata idle", bus_rdata, 16'h0000);

    // R2/R3 transmit sweep over every value
    wr(3'd2, 16'h0001);
    rd(3'd2, rv); check("R13 ctrl readback", rv, 16'h0001);
    for (int v = 0; v < 16; v++) begin
      n0 = loads;
      wr(3'd4, 16'(v) | 16'hFFF0);
      idle(2);
      check("R2 load count", 16'(loads - n0), 16'd1);
      check("R2 load byte", 16'(last_load), 16'(v));
      rd(3'd0, rv); check("R2 status after load", rv, 16'h0001);
      shift_done();
      rd(3'd0, rv); check("R3 complete", rv, 16'h0003);
    end

    // R4 held while transmit disabled
    wr(3'd2, 16'h0000);
    n0 = loads;
    wr(3'd4, 16'h0005);
    idle(3);
    rd(3'd0, rv); check("R4 held status", rv, 16'h0002);
    check("R4 no load", 16'(loads - n0), 16'd0);
    wr(3'd2, 16'h0001);
    idle(2);
    check("R4 load on enable", 16'(loads - n0), 16'd1);
    check("R4 byte", 16'(last_load), 16'h0005);
    shift_done();

    // R5 discard held byte
    wr(3'd2, 16'h0000);
    n0 = loads;
    wr(3'd4, 16'h0009);
    wr(3'd2, 16'h0004);
    rd(3'd0, rv); check("R5 status after discard", rv, 16'h0003);
    rd(3'd2, rv); check("R5 clr bit reads 0", rv, 16'h0000);
    wr(3'd2, 16'h0001);
    idle(3);
    check("R5 nothing loaded", 16'(loads - n0), 16'd0);

    // R6/R8/R9/R10 receive sweep
    wr(3'd2, 16'h0002);
    for (int v = 0; v < 16; v++) begin
      for (int e = 0; e < 4; e++) begin
        logic [15:0] ev;
        ev = 16'((e & 1) << 3) | 16'(((e >> 1) & 1) << 4) | ((e != 0) ? 16'h0040 : 16'h0000);
        rx_evt(DW'(v), e[0], e[1]);
        rd(3'd0, rv); check("R6 R8 status", rv, 16'h0007 | ev);
        rd(3'd1, rv); check("R10 errview", rv, ev);
        rd(3'd5, rv); check("R9 data", rv, 16'(v));
        rd(3'd0, rv); check("R9 cleared", rv, 16'h0003);
      end
    end

    // R7 overrun
    rx_evt(4'd3, 1'b0, 1'b0);
    rx_evt(4'd7, 1'b1, 1'b0);
    rd(3'd0, rv); check("R7 overrun status", rv, 16'h0067);
    rd(3'd5, rv); check("R7 old byte kept", rv, 16'h0003);
    rd(3'd0, rv); check("R7 cleared", rv, 16'h0003);

    // R10 selective clear
    rx_evt(4'd6, 1'b1, 1'b1);
    wr(3'd1, 16'h0010);
    rd(3'd1, rv); check("R10 keep framing", rv, 16'h0050);
    wr(3'd1, 16'h0000);
    rd(3'd1, rv); check("R10 all cleared", rv, 16'h0000);
    rd(3'd0, rv); check("R10 full kept", rv, 16'h0007);
    rd(3'd5, rv); check("R10 data", rv, 16'h0006);

    // R11 receive disabled
    wr(3'd2, 16'h0000);
    rx_evt(4'd11, 1'b1, 1'b1);
    rd(3'd0, rv); check("R11 ignored", rv, 16'h0003);
    rd(3'd5, rv); check("R11 data unchanged", rv, 16'h0006);

    // R12 interrupt sweep in three flag states
    for (int s = 0; s < 3; s++) begin
      logic [15:0] st;
      if (s == 0) begin
        st = 16'h0003;
      end else if (s == 1) begin
        wr(3'd2, 16'h0002);
        rx_evt(4'd1, 1'b1, 1'b0);
        st = 16'h004F;
      end else begin
        rd(3'd5, rv);
        wr(3'd2, 16'h0000);
        wr(3'd4, 16'h0002);
        st = 16'h0002;
      end
      for (int m = 0; m < 16; m++) begin
        logic [15:0] mv;
        mv = 16'(m & 7) | 16'(((m >> 3) & 1) << 6);
        wr(3'd3, mv | 16'hFFB8 & 16'h0000);
        idle(2);
        check("R12 irq", {15'd0, irq}, {15'd0, |(st & mv)});
      end
    end
    wr(3'd3, 16'hFFFF);
    rd(3'd3, rv); check("R12 mask bits", rv, 16'h0047);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule